// File: doc/BRIEF.md
# Load-Monitoring Dual Packet Queue

This block is the storage beneath one cell of a cooperative compute array. It keeps two first-in first-out queues of 48-bit operation packets. The inbound queue is filled by the local router and drained by the local compute agent. The outbound queue holds packets the router will forward: results pushed by the agent, and work that the cell hands off to a neighbour. The live occupancy of the inbound queue is exported on every cycle as the cell's workload figure. Neighbouring agents compare this figure to decide where spare capacity lies.

An admission stage decides whether each arriving packet is written. It declines a packet when the inbound queue is full, when the cell has been sealed by its fault flag, or when the packet is cooperative traffic and the refusal input is high. In element-by-element distribution mode it also declines a packet once the current task has already delivered as many packets as the queue holds. A declined packet produces a one-cycle reject pulse, so the router can forward it elsewhere.

A migration engine hands pending work off to a neighbour. It is a three-state machine. `MG_IDLE` waits for a request. `MG_MOVE` transfers one packet per cycle from the inbound head to the outbound tail, when the shared ports are free. `MG_WAIT` holds while the outbound queue is full. Its transitions are:
- `MG_IDLE` to `MG_MOVE` on a request with a non-zero count.
- `MG_MOVE` to `MG_IDLE` when the count is used up or the inbound queue is empty.
- `MG_MOVE` to `MG_WAIT` when the outbound queue is full.
- `MG_WAIT` to `MG_MOVE` once space frees.

Top module: `loadwell_buf`

## Requirements
- R1: The inbound queue holds 32 packets of 48 bits in arrival order. `agent_pkt` shows the oldest entry and `agent_pop` removes it. A pop while the queue is empty has no effect.
- R2: The outbound queue holds 8 packets of 48 bits in arrival order. `res_push` appends `res_pkt` unless the queue is full, in which case the packet is dropped. `out_pkt` shows the oldest entry and `out_pop` removes it.
- R3: An accepted write and a pop of the same queue in the same cycle both take effect, so the occupancy is unchanged.
- R4: `load` equals the number of packets in the inbound queue. It updates at the clock edge that performs the push or pop.
- R5: `in_full`, `in_empty`, `out_full` and `out_empty` are registered. They reflect the occupancy after each clock edge.
- R6: A packet offered on `in_valid` is either written, or it is declined and dropped. `in_reject` is high for exactly the one cycle after a declined offer, and low after an accepted one. Offers to a full inbound queue are declined.
- R7: Bit 47 of a packet set to 1 marks cooperative traffic. While `refuse_coop` is high, cooperative packets are declined and packets with bit 47 at 0 are still accepted.
- R8: From the cycle in which `fault` is high, every offered packet is declined until reset, even after `fault` falls. Pops still drain the remaining entries in order.
- R9: A counter records the packets accepted since reset or the last `task_start` pulse. While `elem_mode` is high and this count has reached 32, packets are declined even if the queue has room.
- R10: A `mig_req` in idle with `mig_cnt` > 0 latches `mig_dir` and `mig_cnt`. The engine then moves inbound head packets to the outbound queue until it has moved that many or the inbound queue empties. Each moved packet gets bit 47 set to 1 and bits 46:45 set to the direction, with bits 44:0 kept. `mig_busy` is high while the engine is not idle.
- R11: A move happens only in cycles where `agent_pop` and `res_push` are low and the outbound queue is not full. A full outbound queue stalls migration, and it resumes when space frees.
- R12: Reset empties both queues, clears the task counter and the fault seal, and returns the migration engine to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Router offers a packet to the inbound queue |
| in_pkt | input | 48 | Offered packet, bit 47 = cooperative |
| in_reject | output | 1 | Pulse: previous cycle's offer was declined |
| refuse_coop | input | 1 | Decline cooperative packets |
| fault | input | 1 | Cell fault flag, seals the block |
| elem_mode | input | 1 | Element-by-element distribution mode |
| task_start | input | 1 | Clears the per-task accept counter |
| agent_pop | input | 1 | Agent consumes the inbound head |
| agent_pkt | output | 48 | Inbound head packet |
| in_full | output | 1 | Inbound queue full |
| in_empty | output | 1 | Inbound queue empty |
| load | output | 6 | Inbound occupancy (workload) |
| res_push | input | 1 | Agent appends a result to the outbound queue |
| res_pkt | input | 48 | Result packet |
| out_pop | input | 1 | Router takes the outbound head |
| out_pkt | output | 48 | Outbound head packet |
| out_full | output | 1 | Outbound queue full |
| out_empty | output | 1 | Outbound queue empty |
| mig_req | input | 1 | Migration request |
| mig_dir | input | 2 | Migration target direction |
| mig_cnt | input | 6 | Number of packets to migrate |
| mig_busy | output | 1 | Migration engine not idle |

## Verification
The bench fills the inbound queue to exactly 32 entries and then offers a 33rd packet. A design with an off-by-one full flag would either accept that packet and corrupt the oldest entry, or decline the 32nd. The bench also runs element mode with the queue half drained, so a design that limited on occupancy instead of on accepted count would admit a 33rd packet for the task. Fault sealing is checked after the flag falls again: a design that gated writes only on the live flag would accept the next packet. Migration is checked with a count larger than the queue contents, with the outbound queue nearly full so that the engine stalls and resumes, and with the agent popping on every cycle. A design with the wrong port priority would lose, duplicate or reorder packets, or would mis-tag the direction bits.

// File: rtl/lwb_pkg.sv
package lwb_pkg;
    localparam int PKT_W    = 48;
    localparam int COOP_BIT = 47;
    localparam int DIR_HI   = 46;
    localparam int DIR_LO   = 45;

    typedef enum logic [1:0] {
        MG_IDLE = 2'd0,
        MG_MOVE = 2'd1,
        MG_WAIT = 2'd2
    } mig_st_e;
endpackage

// File: rtl/lwb_fifo.sv
module lwb_fifo #(
    parameter int W     = 48,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
    localparam logic [CW-1:0] DEP_V = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt_n;

    always_comb begin
        cnt_n = count + {{(CW-1){1'b0}}, wr_en} - {{(CW-1){1'b0}}, rd_en};
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            full  <= 1'b0;
            empty <= 1'b1;
        end else begin
            if (wr_en) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (rd_en) rp <= (rp == LAST) ? '0 : rp + 1'b1;
            count <= cnt_n;
            full  <= (cnt_n == DEP_V);
            empty <= (cnt_n == '0);
        end
    end

    assign rd_data = mem[rp];
endmodule

// File: rtl/lwb_admit.sv
module lwb_admit #(
    parameter int LIMIT = 32,
    parameter int CW    = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_coop,
    input  logic in_full,
    input  logic refuse_coop,
    input  logic fault,
    input  logic elem_mode,
    input  logic task_start,
    output logic wr_ok,
    output logic reject_q
);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    logic          sealed_q;
    logic [CW-1:0] taken_q;
    logic          blocked;

    always_comb begin
        blocked = in_full | sealed_q | fault
                | (refuse_coop & in_coop)
                | (elem_mode & (taken_q >= LIM_V));
        wr_ok   = in_valid & ~blocked;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sealed_q <= 1'b0;
            reject_q <= 1'b0;
            taken_q  <= '0;
        end else begin
            sealed_q <= sealed_q | fault;
            reject_q <= in_valid & blocked;
            if (task_start)
                taken_q <= '0;
            else if (wr_ok && taken_q != LIM_V)
                taken_q <= taken_q + 1'b1;
        end
    end
endmodule

// File: rtl/lwb_mig.sv
module lwb_mig
    import lwb_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mig_req,
    input  logic [1:0]    mig_dir,
    input  logic [CW-1:0] mig_cnt,
    input  logic          in_empty,
    input  logic          out_full,
    input  logic          agent_pop,
    input  logic          res_push,
    output logic          busy,
    output logic          move,
    output logic [1:0]    tag_dir
);
    mig_st_e       st, st_n;
    logic [CW-1:0] left_q;
    logic [1:0]    dir_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= MG_IDLE;
            left_q <= '0;
            dir_q  <= '0;
        end else begin
            st <= st_n;
            if (st == MG_IDLE && mig_req) begin
                left_q <= mig_cnt;
                dir_q  <= mig_dir;
            end else if (move) begin
                left_q <= left_q - 1'b1;
            end
        end
    end

    always_comb begin
        st_n = st;
        unique case (st)
            MG_IDLE: st_n = (mig_req && mig_cnt != '0) ? MG_MOVE : MG_IDLE;
            MG_MOVE: begin
                if (left_q == '0 || in_empty) st_n = MG_IDLE;
                else if (out_full)            st_n = MG_WAIT;
                else                          st_n = MG_MOVE;
            end
            MG_WAIT: st_n = out_full ? MG_WAIT : MG_MOVE;
            default: st_n = MG_IDLE;
        endcase
    end

    always_comb begin
        busy    = (st != MG_IDLE);
        move    = (st == MG_MOVE) && (left_q != '0) && !in_empty
                  && !out_full && !agent_pop && !res_push;
        tag_dir = dir_q;
    end
endmodule

// File: rtl/loadwell_buf.sv
module loadwell_buf
    import lwb_pkg::*;
#(
    parameter int IN_DEPTH  = 32,
    parameter int OUT_DEPTH = 8,
    localparam int LW = $clog2(IN_DEPTH + 1),
    localparam int OW = $clog2(OUT_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PKT_W-1:0] in_pkt,
    output logic             in_reject,
    input  logic             refuse_coop,
    input  logic             fault,
    input  logic             elem_mode,
    input  logic             task_start,
    input  logic             agent_pop,
    output logic [PKT_W-1:0] agent_pkt,
    output logic             in_full,
    output logic             in_empty,
    output logic [LW-1:0]    load,
    input  logic             res_push,
    input  logic [PKT_W-1:0] res_pkt,
    input  logic             out_pop,
    output logic [PKT_W-1:0] out_pkt,
    output logic             out_full,
    output logic             out_empty,
    input  logic             mig_req,
    input  logic [1:0]       mig_dir,
    input  logic [LW-1:0]    mig_cnt,
    output logic             mig_busy
);
    logic             in_wr, in_rd, out_wr, out_rd, mig_move;
    logic [1:0]       tag_dir;
    logic [PKT_W-1:0] out_wdata;
    logic [OW-1:0]    out_cnt;

    lwb_admit #(.LIMIT(IN_DEPTH), .CW(LW)) u_admit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_coop(in_pkt[COOP_BIT]), .in_full(in_full),
        .refuse_coop(refuse_coop), .fault(fault),
        .elem_mode(elem_mode), .task_start(task_start),
        .wr_ok(in_wr), .reject_q(in_reject)
    );

    lwb_mig #(.CW(LW)) u_mig (
        .clk(clk), .rst_n(rst_n), .mig_req(mig_req), .mig_dir(mig_dir),
        .mig_cnt(mig_cnt), .in_empty(in_empty), .out_full(out_full),
        .agent_pop(agent_pop), .res_push(res_push),
        .busy(mig_busy), .move(mig_move), .tag_dir(tag_dir)
    );

    always_comb begin
        in_rd     = (agent_pop && !in_empty) || mig_move;
        out_wr    = (res_push && !out_full) || mig_move;
        out_rd    = out_pop && !out_empty;
        out_wdata = mig_move ? {1'b1, tag_dir, agent_pkt[DIR_LO-1:0]} : res_pkt;
    end

    lwb_fifo #(.W(PKT_W), .DEPTH(IN_DEPTH)) u_inq (
        .clk(clk), .rst_n(rst_n), .wr_en(in_wr), .wr_data(in_pkt),
        .rd_en(in_rd), .rd_data(agent_pkt), .count(load),
        .full(in_full), .empty(in_empty)
    );

    lwb_fifo #(.W(PKT_W), .DEPTH(OUT_DEPTH)) u_outq (
        .clk(clk), .rst_n(rst_n), .wr_en(out_wr), .wr_data(out_wdata),
        .rd_en(out_rd), .rd_data(out_pkt), .count(out_cnt),
        .full(out_full), .empty(out_empty)
    );
endmodule

// File: rtl/lwb_chk.sv
module lwb_chk #(
    parameter int IN_DEPTH  = 32,
    parameter int OUT_DEPTH = 8,
    parameter int LW = 6,
    parameter int OW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_coop,
    input logic          refuse_coop,
    input logic          fault,
    input logic          in_reject,
    input logic [LW-1:0] load,
    input logic          in_wr,
    input logic          in_rd,
    input logic          in_empty,
    input logic          out_wr,
    input logic          out_full,
    input logic [OW-1:0] out_cnt,
    input logic          mig_move
);
    logic live, seen_fault;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live       <= 1'b0;
            seen_fault <= 1'b0;
        end else begin
            live       <= 1'b1;
            seen_fault <= seen_fault | fault;
        end
    end

    a_r4_load_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (load == $past(load) + LW'($past(in_wr)) - LW'($past(in_rd))));

    a_r1_in_bound: assert property (@(posedge clk) disable iff (!rst_n)
        load <= LW'(IN_DEPTH));

    a_r1_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        in_rd |-> !in_empty);

    a_r2_out_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wr |-> !out_full) and (out_cnt <= OW'(OUT_DEPTH)));

    a_r7_refuse_coop: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && refuse_coop && in_coop) |=> in_reject);

    a_r8_sealed: assert property (@(posedge clk) disable iff (!rst_n)
        (fault || seen_fault) |-> !in_wr);

    a_r11_move_room: assert property (@(posedge clk) disable iff (!rst_n)
        mig_move |-> !out_full);
endmodule

bind loadwell_buf lwb_chk #(
    .IN_DEPTH(IN_DEPTH), .OUT_DEPTH(OUT_DEPTH), .LW(LW), .OW(OW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_coop(in_pkt[47]),
    .refuse_coop(refuse_coop), .fault(fault), .in_reject(in_reject),
    .load(load), .in_wr(in_wr), .in_rd(in_rd), .in_empty(in_empty),
    .out_wr(out_wr), .out_full(out_full), .out_cnt(out_cnt),
    .mig_move(mig_move)
);

// File: tb/sim_loadwell_buf.sv
module sim_loadwell_buf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 0, refuse_coop = 0, fault = 0, elem_mode = 0, task_start = 0;
    logic [47:0] in_pkt = '0, res_pkt = '0;
    logic        agent_pop = 0, res_push = 0, out_pop = 0, mig_req = 0;
    logic [1:0]  mig_dir = '0;
    logic [5:0]  mig_cnt = '0;
    logic        in_reject, in_full, in_empty, out_full, out_empty, mig_busy;
    logic [47:0] agent_pkt, out_pkt;
    logic [5:0]  load;

    int n_chk = 0, n_bad = 0;
    logic [47:0] v;
    logic [47:0] exp_q [$];

    always #2 clk = ~clk;

    loadwell_buf u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pkt(in_pkt),
        .in_reject(in_reject), .refuse_coop(refuse_coop), .fault(fault),
        .elem_mode(elem_mode), .task_start(task_start), .agent_pop(agent_pop),
        .agent_pkt(agent_pkt), .in_full(in_full), .in_empty(in_empty),
        .load(load), .res_push(res_push), .res_pkt(res_pkt), .out_pop(out_pop),
        .out_pkt(out_pkt), .out_full(out_full), .out_empty(out_empty),
        .mig_req(mig_req), .mig_dir(mig_dir), .mig_cnt(mig_cnt),
        .mig_busy(mig_busy)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [47:0] mk(input bit coop, input int k);
        return {coop, 2'b00, 13'(k), 32'(k * 40503 + 7)};
    endfunction

    function automatic logic [47:0] tag(input logic [47:0] p, input logic [1:0] d);
        return {1'b1, d, p[44:0]};
    endfunction

    task automatic push(input logic [47:0] p);
        @(negedge clk); in_valid = 1; in_pkt = p;
        @(negedge clk); in_valid = 0;
    endtask

    task automatic pop_in(output logic [47:0] q);
        @(negedge clk); q = agent_pkt; agent_pop = 1;
        @(negedge clk); agent_pop = 0;
    endtask

    task automatic pop_out(output logic [47:0] q);
        @(negedge clk); q = out_pkt; out_pop = 1;
        @(negedge clk); out_pop = 0;
    endtask

    task automatic res(input logic [47:0] p);
        @(negedge clk); res_push = 1; res_pkt = p;
        @(negedge clk); res_push = 0;
    endtask

    task automatic req_mig(input logic [1:0] d, input logic [5:0] c);
        @(negedge clk); mig_req = 1; mig_dir = d; mig_cnt = c;
        @(negedge clk); mig_req = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && mig_busy; i++) @(negedge clk);
        chk("R10 engine returns idle", {63'd0, mig_busy}, 64'd0);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        #(4 * 100000);
        n_bad++;
        $display("FAIL R12 watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        chk("R12 load after reset", 64'(load), 64'd0);
        chk("R12 in_empty after reset", 64'(in_empty), 64'd1);
        chk("R12 out_empty after reset", 64'(out_empty), 64'd1);
        chk("R12 mig_busy after reset", 64'(mig_busy), 64'd0);
        chk("R5 in_full after reset", 64'(in_full), 64'd0);

        // R4/R6: fill 32, load tracks each push
        for (int i = 0; i < 32; i++) begin
            push(mk(0, i));
            chk("R4 load after push", 64'(load), 64'(i + 1));
            chk("R6 no reject on accept", 64'(in_reject), 64'd0);
        end
        chk("R5 in_full at 32", 64'(in_full), 64'd1);
        push(mk(0, 99));
        chk("R6 reject when full", 64'(in_reject), 64'd1);
        chk("R6 load unchanged when full", 64'(load), 64'd32);
        @(negedge clk);
        chk("R6 reject is one cycle", 64'(in_reject), 64'd0);

        // R3: simultaneous push and pop
        pop_in(v);
        chk("R1 first out is first in", 64'(v), 64'(mk(0, 0)));
        @(negedge clk); in_valid = 1; in_pkt = mk(0, 32); agent_pop = 1;
        @(negedge clk); in_valid = 0; agent_pop = 0;
        chk("R3 load unchanged on push+pop", 64'(load), 64'd31);
        for (int i = 2; i <= 32; i++) begin
            pop_in(v);
            chk("R1 inbound order", 64'(v), 64'(mk(0, i)));
        end
        chk("R5 in_empty after drain", 64'(in_empty), 64'd1);
        @(negedge clk); agent_pop = 1;
        @(negedge clk); agent_pop = 0;
        chk("R1 pop on empty ignored", 64'(load), 64'd0);

        // R7 refusal
        refuse_coop = 1;
        push(mk(1, 5));
        chk("R7 coop refused", 64'(in_reject), 64'd1);
        chk("R7 coop not stored", 64'(load), 64'd0);
        push(mk(0, 6));
        chk("R7 distribution accepted", 64'(load), 64'd1);
        refuse_coop = 0;
        push(mk(1, 7));
        chk("R7 coop accepted when allowed", 64'(load), 64'd2);
        pop_in(v); chk("R7 stored order", 64'(v), 64'(mk(0, 6)));
        pop_in(v); chk("R7 stored order", 64'(v), 64'(mk(1, 7)));

        // R2 outbound
        for (int i = 0; i < 9; i++) res(mk(0, 200 + i));
        chk("R5 out_full at 8", 64'(out_full), 64'd1);
        for (int i = 0; i < 8; i++) begin
            pop_out(v);
            chk("R2 outbound order", 64'(v), 64'(mk(0, 200 + i)));
        end
        chk("R2 ninth result dropped", 64'(out_empty), 64'd1);

        // R10 migration, count below contents
        for (int i = 0; i < 10; i++) push(mk(0, 300 + i));
        req_mig(2'd2, 6'd4);
        wait_idle();
        chk("R10 load after move 4", 64'(load), 64'd6);
        for (int i = 0; i < 4; i++) begin
            pop_out(v);
            chk("R10 tagged moved packet", 64'(v), 64'(tag(mk(0, 300 + i), 2'd2)));
        end
        chk("R10 exactly 4 moved", 64'(out_empty), 64'd1);
        // count above contents
        req_mig(2'd3, 6'd20);
        wait_idle();
        chk("R10 inbound emptied", 64'(load), 64'd0);
        for (int i = 4; i < 10; i++) begin
            pop_out(v);
            chk("R10 tagged moved packet", 64'(v), 64'(tag(mk(0, 300 + i), 2'd3)));
        end
        chk("R10 only contents moved", 64'(out_empty), 64'd1);

        // R11 stall on full outbound
        for (int i = 0; i < 6; i++) res(mk(0, 400 + i));
        for (int i = 0; i < 5; i++) push(mk(0, 500 + i));
        req_mig(2'd1, 6'd5);
        repeat (6) @(negedge clk);
        chk("R11 stalled load", 64'(load), 64'd3);
        chk("R11 busy while stalled", 64'(mig_busy), 64'd1);
        chk("R11 out_full while stalled", 64'(out_full), 64'd1);
        for (int i = 0; i < 3; i++) begin
            pop_out(v);
            chk("R11 result order", 64'(v), 64'(mk(0, 400 + i)));
        end
        wait_idle();
        chk("R11 resumed and finished", 64'(load), 64'd0);
        exp_q.delete();
        for (int i = 3; i < 6; i++) exp_q.push_back(mk(0, 400 + i));
        for (int i = 0; i < 5; i++) exp_q.push_back(tag(mk(0, 500 + i), 2'd1));
        for (int i = 0; i < 8; i++) begin
            pop_out(v);
            chk("R11 outbound after resume", 64'(v), 64'(exp_q[i]));
        end

        // R11 agent pop has priority over migration
        for (int i = 0; i < 4; i++) push(mk(0, 600 + i));
        @(negedge clk); mig_req = 1; mig_dir = 2'd0; mig_cnt = 6'd4; agent_pop = 1;
        @(negedge clk); mig_req = 0;
        repeat (3) @(negedge clk);
        agent_pop = 0;
        wait_idle();
        chk("R11 agent consumed all", 64'(load), 64'd0);
        chk("R11 nothing migrated", 64'(out_empty), 64'd1);

        // R9 element mode limit
        elem_mode = 1;
        @(negedge clk); task_start = 1;
        @(negedge clk); task_start = 0;
        for (int i = 0; i < 20; i++) push(mk(0, 700 + i));
        for (int i = 0; i < 20; i++) pop_in(v);
        for (int i = 20; i < 32; i++) begin
            push(mk(0, 700 + i));
            chk("R9 accepted under limit", 64'(in_reject), 64'd0);
        end
        push(mk(0, 799));
        chk("R9 33rd declined", 64'(in_reject), 64'd1);
        chk("R9 load with room", 64'(load), 64'd12);
        @(negedge clk); task_start = 1;
        @(negedge clk); task_start = 0;
        push(mk(0, 800));
        chk("R9 new task accepted", 64'(load), 64'd13);
        elem_mode = 0;
        for (int i = 0; i < 13; i++) pop_in(v);

        // R8 fault seal
        for (int i = 0; i < 3; i++) push(mk(0, 900 + i));
        @(negedge clk); fault = 1; in_valid = 1; in_pkt = mk(0, 950);
        @(negedge clk); fault = 0; in_valid = 0;
        chk("R8 declined while fault", 64'(in_reject), 64'd1);
        push(mk(0, 951));
        chk("R8 still sealed", 64'(in_reject), 64'd1);
        chk("R8 load unchanged", 64'(load), 64'd3);
        for (int i = 0; i < 3; i++) begin
            pop_in(v);
            chk("R8 drain order", 64'(v), 64'(mk(0, 900 + i)));
        end

        // R12 reset clears seal
        do_reset();
        @(negedge clk);
        chk("R12 load after reset", 64'(load), 64'd0);
        push(mk(0, 1000));
        chk("R12 seal cleared", 64'(load), 64'd1);
        chk("R12 head after reset", 64'(agent_pkt), 64'(mk(0, 1000)));

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule